// File: doc/BRIEF.md
# Flash Word DMA Engine

This block is the transfer engine of a serial flash controller. Software programs a flash address, a system memory address and a length, then writes a go bit. The engine moves 32-bit words one at a time. By default it reads from the memory-mapped flash window and writes to system memory; a direction bit reverses this. A third mode only reads flash words and adds them up, without touching system memory. Software uses that sum to judge whether a set of read timing settings returns good data.

The programmed length is not a byte count. It is an offset above a minimum transfer size, START_LEN (1 or 4 bytes depending on the variant), so a value of zero still moves data. The resulting size is rounded up to whole words. While a transfer runs, the length register shows the bytes still to go. A single running checksum accumulates every word moved, whatever the mode. Both request ports use a valid/ready handshake, and each word finishes only when its handshake completes.

Top module: `flash_word_dma`

## Requirements
- R1: The transfer covers (length field + START_LEN) bytes, rounded up to the next multiple of 4, and moves exactly that many bytes divided by 4 words.
- R2: The length register is at offset 3. A write keeps only its low LEN_W (25) bits.
- R3: The flash address register (offset 1) is ANDed with FLASH_MASK (default 0x0FFFFFFC) on every write and after every step. The memory address register (offset 2) is handled the same way with MEM_MASK.
- R4: Each completed word advances the flash address by 4. In the copy modes the memory address also advances by 4. In checksum-only mode the memory address is left unchanged.
- R5: After each word, the length register reads the number of bytes still to move. It reads 0 when the transfer ends.
- R6: The checksum register (offset 4) adds every moved word modulo 2^32. It is cleared when a transfer starts, and by any write to offset 4 while the engine is idle.
- R7: Control bit 1 clear means each word is read from flash and the same value is written to memory. Set means each word is read from memory and written to flash.
- R8: Control bit 2 selects checksum-only mode. In this mode only flash reads are issued, the memory request valid is never raised, and bit 1 has no effect.
- R9: Writing offset 0 with bit 0 set while idle starts a transfer. Control bit 8 (busy) reads 1 until the last word completes. Bit 9 (done) is then set and stays set until the next start. No request is issued while idle.
- R10: Once a request is raised, it holds its valid, address, write flag and write data until ready is seen. A word is counted only on a cycle with valid and ready both high.
- R11: While busy, register writes are ignored. This includes a second go and writes to the addresses, length and checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| flashValid | output | 1 | Flash window request valid |
| flashWrite | output | 1 | Flash request is a write |
| flashAddr | output | 32 | Flash word address |
| flashWData | output | 32 | Flash write data |
| flashReady | input | 1 | Flash request accepted |
| flashRData | input | 32 | Flash read data, valid with flashReady on a read |
| memValid | output | 1 | System memory request valid |
| memWrite | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory word address |
| memWData | output | 32 | Memory write data |
| memReady | input | 1 | Memory request accepted |
| memRData | input | 32 | Memory read data, valid with memReady on a read |

## Verification
The bench builds the engine with START_LEN = 1 and MEM_MASK = 0x000FFFFC. With a one-byte minimum, the rounding boundaries can be reached by short transfers: field 0 and 3 give one word, field 4 gives two words, and fields 7, 9 and 14 give 2, 3 and 4 words. The narrow memory mask, together with the default flash mask, makes both addresses wrap inside a three-word transfer started just below the top of each window. A pseudo-random ready pattern exercises request holding. Writes issued in the middle of a transfer exercise R11.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  localparam int ADDR_W = 3;
  localparam int WORD_W = 32;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_FADDR = 3'd1;
  localparam logic [ADDR_W-1:0] REG_MADDR = 3'd2;
  localparam logic [ADDR_W-1:0] REG_LEN   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_SUM   = 3'd4;

  localparam int CB_GO      = 0;
  localparam int CB_TOFLASH = 1;
  localparam int CB_SUMONLY = 2;
  localparam int CB_BUSY    = 8;
  localparam int CB_DONE    = 9;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } fdmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // start: load rounded length, clear sum
    logic capture;  // latch source word for the store phase
    logic step;     // one word finished
    logic useLive;  // sum the live source word instead of the held one
  } dpStrobe_t;
endpackage

// File: rtl/fdma_ctrl.sv
module fdma_ctrl
  import fdma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      goReq,
  input  logic      toFlash,
  input  logic      sumOnly,
  input  logic      lastBeat,
  input  logic      flashReady,
  input  logic      memReady,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      flashValid,
  output logic      flashWrite,
  output logic      memValid,
  output logic      memWrite
);
  fdmaState_e stateQ, stateD;
  logic doneQ;
  logic fromMem, srcReady, dstReady, startOk;

  assign fromMem  = toFlash & ~sumOnly;
  assign srcReady = fromMem ? memReady : flashReady;
  assign dstReady = toFlash ? flashReady : memReady;
  assign startOk  = goReq && (stateQ == ST_IDLE);

  always_comb begin
    stateD     = stateQ;
    strobe     = '0;
    flashValid = 1'b0;
    flashWrite = 1'b0;
    memValid   = 1'b0;
    memWrite   = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (startOk) begin
          strobe.load = 1'b1;
          stateD      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        flashValid = ~fromMem;
        memValid   = fromMem;
        if (srcReady) begin
          if (sumOnly) begin
            strobe.step    = 1'b1;
            strobe.useLive = 1'b1;
            stateD         = lastBeat ? ST_IDLE : ST_FETCH;
          end else begin
            strobe.capture = 1'b1;
            stateD         = ST_STORE;
          end
        end
      end
      ST_STORE: begin
        flashValid = toFlash;
        flashWrite = toFlash;
        memValid   = ~toFlash;
        memWrite   = ~toFlash;
        if (dstReady) begin
          strobe.step = 1'b1;
          stateD      = lastBeat ? ST_IDLE : ST_FETCH;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobe.load)                doneQ <= 1'b0;
      else if (strobe.step && lastBeat) doneQ <= 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busy);

  assert_finish_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && lastBeat) |=> (!busy && doneQ));

  assert_sum_mem_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sumOnly) |-> !memValid);
endmodule

// File: rtl/fdma_datapath.sv
module fdma_datapath
  import fdma_pkg::*;
#(
  parameter int          START_LEN  = 1,
  parameter int          LEN_W      = 25,
  parameter logic [31:0] FLASH_MASK = 32'h0FFF_FFFC,
  parameter logic [31:0] MEM_MASK   = 32'h3FFF_FFFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              busy,
  input  logic              done,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] flashRData,
  input  logic [WORD_W-1:0] memRData,
  output logic [WORD_W-1:0] flashAddr,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] wData,
  output logic              toFlash,
  output logic              sumOnly,
  output logic              lastBeat
);
  localparam int CW = LEN_W + 1;  // room for the rounded maximum

  logic [WORD_W-1:0] flashAddrQ, memAddrQ, sumQ, holdQ, srcData;
  logic [CW-1:0]     lenQ, effLen, roundLen;
  logic              toFlashQ, sumOnlyQ, cfgWr;

  assign cfgWr    = regWrEn && !busy;
  assign effLen   = CW'(lenQ[LEN_W-1:0]) + CW'(START_LEN);
  assign roundLen = (effLen + CW'(3)) & ~CW'(3);
  assign srcData  = (toFlashQ && !sumOnlyQ) ? memRData : flashRData;
  assign lastBeat = (lenQ == CW'(4));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toFlashQ <= 1'b0;
      sumOnlyQ <= 1'b0;
    end else if (cfgWr && regAddr == REG_CTRL) begin
      toFlashQ <= regWrData[CB_TOFLASH];
      sumOnlyQ <= regWrData[CB_SUMONLY];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flashAddrQ <= '0;
      memAddrQ   <= '0;
      lenQ       <= '0;
      sumQ       <= '0;
    end else if (strobe.load) begin
      lenQ <= roundLen;
      sumQ <= '0;
    end else if (strobe.step) begin
      flashAddrQ <= (flashAddrQ + 32'd4) & FLASH_MASK;
      if (!sumOnlyQ) memAddrQ <= (memAddrQ + 32'd4) & MEM_MASK;
      lenQ <= lenQ - CW'(4);
      sumQ <= sumQ + (strobe.useLive ? srcData : holdQ);
    end else if (cfgWr) begin
      case (regAddr)
        REG_FADDR: flashAddrQ <= regWrData & FLASH_MASK;
        REG_MADDR: memAddrQ   <= regWrData & MEM_MASK;
        REG_LEN:   lenQ       <= {1'b0, regWrData[LEN_W-1:0]};
        REG_SUM:   sumQ       <= '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               holdQ <= '0;
    else if (strobe.capture) holdQ <= srcData;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdData[CB_TOFLASH] = toFlashQ;
        regRdData[CB_SUMONLY] = sumOnlyQ;
        regRdData[CB_BUSY]    = busy;
        regRdData[CB_DONE]    = done;
      end
      REG_FADDR: regRdData = flashAddrQ;
      REG_MADDR: regRdData = memAddrQ;
      REG_LEN:   regRdData = 32'(lenQ);
      REG_SUM:   regRdData = sumQ;
      default:   regRdData = '0;
    endcase
  end

  assign flashAddr = flashAddrQ;
  assign memAddr   = memAddrQ;
  assign wData     = holdQ;
  assign toFlash   = toFlashQ;
  assign sumOnly   = sumOnlyQ;

  assert_len_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (lenQ[1:0] == 2'b00 && lenQ != '0));

  assert_len_writeback_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (lenQ == $past(lenQ) - CW'(4)));

  assert_sum_cleared_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (sumQ == '0));

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.step) |=> ($stable(flashAddrQ) && $stable(memAddrQ)));
endmodule

// File: rtl/flash_word_dma.sv
module flash_word_dma
  import fdma_pkg::*;
#(
  parameter int          START_LEN  = 1,
  parameter int          LEN_W      = 25,
  parameter logic [31:0] FLASH_MASK = 32'h0FFF_FFFC,
  parameter logic [31:0] MEM_MASK   = 32'h3FFF_FFFC
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        flashValid,
  output logic        flashWrite,
  output logic [31:0] flashAddr,
  output logic [31:0] flashWData,
  input  logic        flashReady,
  input  logic [31:0] flashRData,
  output logic        memValid,
  output logic        memWrite,
  output logic [31:0] memAddr,
  output logic [31:0] memWData,
  input  logic        memReady,
  input  logic [31:0] memRData
);
  dpStrobe_t   strobe;
  logic        busy, done, toFlash, sumOnly, lastBeat, goReq;
  logic [31:0] wData;

  assign goReq = regWrEn && (regAddr == REG_CTRL) && regWrData[CB_GO];

  fdma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .goReq      (goReq),
    .toFlash    (toFlash),
    .sumOnly    (sumOnly),
    .lastBeat   (lastBeat),
    .flashReady (flashReady),
    .memReady   (memReady),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .flashValid (flashValid),
    .flashWrite (flashWrite),
    .memValid   (memValid),
    .memWrite   (memWrite)
  );

  fdma_datapath #(
    .START_LEN  (START_LEN),
    .LEN_W      (LEN_W),
    .FLASH_MASK (FLASH_MASK),
    .MEM_MASK   (MEM_MASK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .busy       (busy),
    .done       (done),
    .strobe     (strobe),
    .flashRData (flashRData),
    .memRData   (memRData),
    .flashAddr  (flashAddr),
    .memAddr    (memAddr),
    .wData      (wData),
    .toFlash    (toFlash),
    .sumOnly    (sumOnly),
    .lastBeat   (lastBeat)
  );

  assign flashWData = wData;
  assign memWData   = wData;

  assert_flash_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flashValid && !flashReady) |=>
      (flashValid && $stable(flashAddr) && $stable(flashWrite) && $stable(flashWData)));

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=>
      (memValid && $stable(memAddr) && $stable(memWrite) && $stable(memWData)));

  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(flashValid && memValid));
endmodule

// File: tb/sim_flash_word_dma.sv
module sim_flash_word_dma;
  localparam int          START = 1;
  localparam logic [31:0] FM    = 32'h0FFF_FFFC;
  localparam logic [31:0] MM    = 32'h000F_FFFC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        flashValid, flashWrite, memValid, memWrite;
  logic [31:0] flashAddr, flashWData, memAddr, memWData;
  logic        flashReady = 1'b0, memReady = 1'b0;
  logic [31:0] flashRData = 32'd0, memRData = 32'd0;

  always #2.5 clk = ~clk;  // 200 MHz

  flash_word_dma #(.START_LEN(START), .MEM_MASK(MM)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .flashValid(flashValid), .flashWrite(flashWrite), .flashAddr(flashAddr),
    .flashWData(flashWData), .flashReady(flashReady), .flashRData(flashRData),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWData(memWData), .memReady(memReady), .memRData(memRData)
  );

  typedef struct {
    bit          isFlash;
    bit          isWrite;
    logic [31:0] addr;
    logic [31:0] data;
    bit          endsBeat;
  } ev_t;

  ev_t         expQ[$];
  int          checks = 0, errors = 0, doneBeats = 0, cyc = 0;
  logic [31:0] expTotal = 0, expSum = 0;
  bit          monOn = 0, readyMode = 0, finished = 0;
  bit [15:0]   lfsr = 16'hACE1;

  function automatic logic [31:0] flashWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h00C0_FFEE;
  endfunction
  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (~a) + 32'h1357_2468;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic takeEvent(input bit isF, input bit isW, input logic [31:0] a, input logic [31:0] d);
    ev_t e;
    if (expQ.size() == 0) begin
      chk(1'b0, "R8 R9 unexpected request", a, 32'd0);
    end else begin
      e = expQ.pop_front();
      chk(e.isFlash == isF && e.isWrite == isW, "R7 R8 port/direction",
          {30'd0, isF, isW}, {30'd0, e.isFlash, e.isWrite});
      chk(a == e.addr, "R3 R4 address", a, e.addr);
      if (isW) chk(d == e.data, "R7 R10 write data", d, e.data);
      if (e.endsBeat) doneBeats++;
    end
  endtask

  // reference model driver/monitor, evaluated every clock away from the edge
  always @(negedge clk) begin
    bit rdy;
    #1;
    if (expQ.size() == 0)
      chk(!(flashValid || memValid), "R9 request while idle",
          {30'd0, flashValid, memValid}, 32'd0);
    rdy  = readyMode ? lfsr[0] : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    flashReady = rdy;
    memReady   = rdy;
    flashRData = flashWord(flashAddr);
    memRData   = memWord(memAddr);
    if (monOn && regAddr == 3'd3 && !regWrEn)
      chk(regRdData == expTotal - 32'(4 * doneBeats), "R5 remaining length",
          regRdData, expTotal - 32'(4 * doneBeats));
    if (flashValid && rdy) takeEvent(1'b1, flashWrite, flashAddr, flashWData);
    if (memValid && rdy)   takeEvent(1'b0, memWrite, memAddr, memWData);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", doneBeats, expTotal / 4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic runXfer(input logic [31:0] fa, input logic [31:0] ma, input logic [31:0] len,
                         input bit toF, input bit sumO, input bit rmode, input bit inject);
    logic [31:0] fam, mam, a, b, w;
    int n;
    fam = fa & FM;
    mam = ma & MM;
    writeReg(3'd1, fa);
    writeReg(3'd2, ma);
    writeReg(3'd3, len);
    expTotal = ((len[24:0] + START) + 3) & ~32'd3;   // R1
    n = int'(expTotal / 4);
    expSum = 0;
    for (int i = 0; i < n; i++) begin
      a = (fam + 32'(4 * i)) & FM;
      b = (mam + 32'(4 * i)) & MM;
      if (sumO) begin
        w = flashWord(a);
        expQ.push_back('{1'b1, 1'b0, a, 32'd0, 1'b1});
      end else if (!toF) begin
        w = flashWord(a);
        expQ.push_back('{1'b1, 1'b0, a, 32'd0, 1'b0});
        expQ.push_back('{1'b0, 1'b1, b, w, 1'b1});
      end else begin
        w = memWord(b);
        expQ.push_back('{1'b0, 1'b0, b, 32'd0, 1'b0});
        expQ.push_back('{1'b1, 1'b1, a, w, 1'b1});
      end
      expSum += w;
    end
    readyMode = rmode;
    doneBeats = 0;
    @(negedge clk);
    regAddr = 3'd0; regWrData = 32'd1 | (32'(toF) << 1) | (32'(sumO) << 2); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd3; monOn = 1;
    if (inject) begin  // R11: writes while busy must not land
      regAddr = 3'd1; regWrData = 32'h0000_0100; regWrEn = 1'b1;
      @(negedge clk);
      regAddr = 3'd0; regWrData = 32'h0000_0003;
      @(negedge clk);
      regAddr = 3'd4; regWrData = 32'h0000_0055;
      @(negedge clk);
      regAddr = 3'd3; regWrEn = 1'b0;
    end
    wait (doneBeats == n);
    @(negedge clk);
    @(negedge clk);
    monOn = 0;
    chk(expQ.size() == 0, "R1 word count", 32'(expQ.size()), 32'd0);
    readChk(3'd0, (32'd1 << 9) | (32'(toF) << 1) | (32'(sumO) << 2), "R9 R11 control status");
    readChk(3'd3, 32'd0, "R5 final length");
    readChk(3'd4, expSum, "R6 checksum");
    readChk(3'd1, (fam + 32'(4 * n)) & FM, "R3 R4 flash address end");
    readChk(3'd2, sumO ? mam : ((mam + 32'(4 * n)) & MM), "R4 R8 memory address end");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    readChk(3'd0, 32'd0, "R9 reset control");
    readChk(3'd3, 32'd0, "R5 reset length");
    readChk(3'd4, 32'd0, "R6 reset checksum");
    // masking
    writeReg(3'd1, 32'hFFFF_FFFF);
    readChk(3'd1, 32'h0FFF_FFFC, "R3 flash mask");
    writeReg(3'd2, 32'hFFFF_FFFF);
    readChk(3'd2, 32'h000F_FFFC, "R3 memory mask");
    writeReg(3'd3, 32'hFFFF_FFFF);
    readChk(3'd3, 32'h01FF_FFFF, "R2 length field");
    // transfers
    runXfer(32'h0000_0100, 32'h0000_0200, 32'd0,  1'b0, 1'b0, 1'b0, 1'b0); // R1 zero field, R7
    runXfer(32'h0FFF_FFF8, 32'h000F_FFF8, 32'd9,  1'b0, 1'b0, 1'b1, 1'b1); // R3 wrap, R10, R11
    runXfer(32'h0000_0041, 32'h0000_0082, 32'd7,  1'b1, 1'b0, 1'b1, 1'b0); // R7 to flash
    runXfer(32'h0000_1000, 32'h0000_2000, 32'd14, 1'b1, 1'b1, 1'b1, 1'b0); // R8 sum only
    runXfer(32'h0000_3000, 32'h0000_4000, 32'd4,  1'b0, 1'b0, 1'b0, 1'b0); // R1 boundary
    runXfer(32'h0000_5000, 32'h0000_6000, 32'd3,  1'b0, 1'b1, 1'b0, 1'b0); // R1 exact word
    // checksum clear while idle
    writeReg(3'd4, 32'hDEAD_BEEF);
    readChk(3'd4, 32'd0, "R6 checksum clear");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule